// File: doc/BRIEF.md
# Instruction pairing detector

This block sits beside a timing model and watches the stream of retired instructions. Each instruction arrives as a 7-bit opcode-family code with a one-cycle valid strobe. The block keeps the family of the last instruction it accepted. For each new instruction it decides whether the ordered pair (earlier family, new family) is one whose execution can overlap. The timing model can then subtract the overlapped cycles.

The relation is ordered, so swapping the two members can change the result. A multiply followed by a divide overlaps, but a divide followed by a multiply does not. Every shift or rotate family counts as the same first member. Any family code outside the table below never pairs, whether it comes first or second.

Family codes (decimal): 0 no-operation, 1 move, 2 move-to-address, 3 load-effective-address, 4 jump, 5 decrement-and-branch, 6 add, 7 subtract, 8 or, 9 and, 10 exclusive-or, 11 not, 12 clear, 13 negate, 14 add-with-extend, 15 subtract-with-extend, 16 BCD add, 17 BCD subtract, 18 exchange, 19 compare, 20 compare-address, 21 bit-test, 22 conditional branch, 23 unsigned multiply, 24 signed multiply, 25 unsigned divide, 26 signed divide, 27 jump-to-subroutine, 32 to 39 the eight shift/rotate families (code bits [6:3] equal 4'b0100). Codes 28 to 31 and 40 to 127 are unlisted.

Top module: `pair_detect`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `prev_fam_o` is 0 (no-operation) and `pair_o` is 0. The first strobed instruction after reset therefore never reports a pair.
- R2: `pair_o` is registered. It reflects the strobe of the previous clock edge, and it is 0 after any edge at which `in_vld` was low.
- R3: `prev_fam_o` takes the value of `in_fam` at every edge where `in_vld` is high. At every other edge it holds its value.
- R4: A shift/rotate family (32 to 39) followed by move (1), move-to-address (2), load-effective-address (3), jump (4) or decrement-and-branch (5) pairs.
- R5: A shift/rotate family followed by any of the codes 6 to 13 (add, subtract, or, and, exclusive-or, not, clear, negate) or 14 to 17 (add/subtract with extend, BCD add/subtract) pairs.
- R6: Exchange (18) followed by decrement-and-branch (5), move (1) or move-to-address (2) pairs.
- R7: Compare (19), compare-address (20) or bit-test (21) followed by a conditional branch (22) pairs.
- R8: A multiply (23, 24) followed by move (1), move-to-address (2), a divide (25, 26) or jump-to-subroutine (27) pairs. A divide followed by a multiply does not pair.
- R9: Add (6) or subtract (7) followed by move (1) pairs, but followed by move-to-address (2) it does not. BCD add (16) or BCD subtract (17) followed by decrement-and-branch (5) pairs.
- R10: Every ordered pair not granted by R4 to R9 does not pair. This includes move followed by decrement-and-branch, divide followed by move, and any pair with an unlisted code in either position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe: a retired instruction is presented this cycle |
| in_fam | input | 7 | Opcode-family code of the presented instruction |
| pair_o | output | 1 | The previous strobe formed an overlapping pair |
| prev_fam_o | output | 7 | Family of the last accepted instruction |

## Verification
Two functions land on the same clock edge: one strobe both decides a pair against the stored family and overwrites that stored family. A stale or early update would judge the wrong pair. The bench provokes this with long runs of back-to-back strobes, where every instruction is second member of one pair and first member of the next. This covers every ordered combination of codes 0 to 47 and a random stream that also uses unlisted codes and idle gaps. A behavioural model predicts the flag and the stored family and compares them with the outputs every cycle. A mid-run reset is placed right before a shift-then-move sequence to confirm that the stored family is cleared before it is compared.

// File: rtl/pair_pkg.sv
package pair_pkg;

    localparam int FAM_W      = 7;
    localparam int SHIFT_LOG  = 3;   // eight shift/rotate codes share the upper bits

    typedef logic [FAM_W-1:0] fam_t;

    localparam fam_t F_NOP   = 7'd0;
    localparam fam_t F_MOVE  = 7'd1;
    localparam fam_t F_MOVEA = 7'd2;
    localparam fam_t F_LEA   = 7'd3;
    localparam fam_t F_JMP   = 7'd4;
    localparam fam_t F_DBCC  = 7'd5;
    localparam fam_t F_ADD   = 7'd6;
    localparam fam_t F_SUB   = 7'd7;
    localparam fam_t F_OR    = 7'd8;
    localparam fam_t F_AND   = 7'd9;
    localparam fam_t F_EOR   = 7'd10;
    localparam fam_t F_NOT   = 7'd11;
    localparam fam_t F_CLR   = 7'd12;
    localparam fam_t F_NEG   = 7'd13;
    localparam fam_t F_ADDX  = 7'd14;
    localparam fam_t F_SUBX  = 7'd15;
    localparam fam_t F_ABCD  = 7'd16;
    localparam fam_t F_SBCD  = 7'd17;
    localparam fam_t F_EXG   = 7'd18;
    localparam fam_t F_CMP   = 7'd19;
    localparam fam_t F_CMPA  = 7'd20;
    localparam fam_t F_BTST  = 7'd21;
    localparam fam_t F_BCC   = 7'd22;
    localparam fam_t F_MULU  = 7'd23;
    localparam fam_t F_MULS  = 7'd24;
    localparam fam_t F_DIVU  = 7'd25;
    localparam fam_t F_DIVS  = 7'd26;
    localparam fam_t F_JSR   = 7'd27;
    localparam fam_t F_SHIFT_BASE = 7'd32;

    // Role of a family when it is the earlier member of a pair.
    typedef enum logic [2:0] {
        LEAD_NONE,
        LEAD_SHIFT,
        LEAD_EXG,
        LEAD_TEST,
        LEAD_MUL,
        LEAD_ADDSUB,
        LEAD_BCD
    } lead_e;

    // Groups a family belongs to when it is the later member of a pair.
    typedef struct packed {
        logic mv;
        logic mva;
        logic lea;
        logic jmp;
        logic dbcc;
        logic alu;
        logic ext;
        logic bcc;
        logic div;
        logic jsr;
    } follow_t;

    function automatic logic is_shift(fam_t f);
        return f[FAM_W-1:SHIFT_LOG] == F_SHIFT_BASE[FAM_W-1:SHIFT_LOG];
    endfunction

    // Which follower groups each leading role accepts.
    function automatic follow_t lead_mask(lead_e l);
        follow_t m;
        m = '0;
        case (l)
            LEAD_SHIFT: begin
                m.mv = 1'b1; m.mva = 1'b1; m.lea = 1'b1; m.jmp = 1'b1;
                m.dbcc = 1'b1; m.alu = 1'b1; m.ext = 1'b1;
            end
            LEAD_EXG:    begin m.dbcc = 1'b1; m.mv = 1'b1; m.mva = 1'b1; end
            LEAD_TEST:   m.bcc = 1'b1;
            LEAD_MUL:    begin m.mv = 1'b1; m.mva = 1'b1; m.div = 1'b1; m.jsr = 1'b1; end
            LEAD_ADDSUB: m.mv = 1'b1;
            LEAD_BCD:    m.dbcc = 1'b1;
            default:     m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pair_lead_class.sv
module pair_lead_class
    import pair_pkg::*;
(
    input  fam_t  fam,
    output lead_e lead
);
    always_comb begin
        if (is_shift(fam)) begin
            lead = LEAD_SHIFT;
        end else begin
            case (fam)
                F_EXG:                 lead = LEAD_EXG;
                F_CMP, F_CMPA, F_BTST: lead = LEAD_TEST;
                F_MULU, F_MULS:        lead = LEAD_MUL;
                F_ADD, F_SUB:          lead = LEAD_ADDSUB;
                F_ABCD, F_SBCD:        lead = LEAD_BCD;
                default:               lead = LEAD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pair_follow_class.sv
module pair_follow_class
    import pair_pkg::*;
(
    input  fam_t    fam,
    output follow_t grp
);
    always_comb begin
        grp      = '0;
        grp.mv   = (fam == F_MOVE);
        grp.mva  = (fam == F_MOVEA);
        grp.lea  = (fam == F_LEA);
        grp.jmp  = (fam == F_JMP);
        grp.dbcc = (fam == F_DBCC);
        grp.alu  = (fam >= F_ADD)  && (fam <= F_NEG);
        grp.ext  = (fam >= F_ADDX) && (fam <= F_SBCD);
        grp.bcc  = (fam == F_BCC);
        grp.div  = (fam == F_DIVU) || (fam == F_DIVS);
        grp.jsr  = (fam == F_JSR);
    end
endmodule

// File: rtl/pair_rule.sv
module pair_rule
    import pair_pkg::*;
(
    input  lead_e   lead,
    input  follow_t grp,
    output logic    ok
);
    localparam int GRP_W = $bits(follow_t);

    follow_t     mask;
    logic [GRP_W-1:0] hit;

    assign mask = lead_mask(lead);

    for (genvar g = 0; g < GRP_W; g++) begin : g_hit
        assign hit[g] = mask[g] & grp[g];
    end

    assign ok = |hit;
endmodule

// File: rtl/pair_detect.sv
module pair_detect
    import pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [FAM_W-1:0] in_fam,
    output logic             pair_o,
    output logic [FAM_W-1:0] prev_fam_o
);
    fam_t    prev_q;
    logic    pair_q;
    lead_e   lead;
    follow_t grp;
    logic    ok;

    pair_lead_class u_lead (
        .fam  (prev_q),
        .lead (lead)
    );

    pair_follow_class u_follow (
        .fam (in_fam),
        .grp (grp)
    );

    pair_rule u_rule (
        .lead (lead),
        .grp  (grp),
        .ok   (ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= F_NOP;
            pair_q <= 1'b0;
        end else begin
            pair_q <= in_vld & ok;
            if (in_vld) begin
                prev_q <= in_fam;
            end
        end
    end

    assign pair_o     = pair_q;
    assign prev_fam_o = prev_q;
endmodule

// File: rtl/pair_detect_chk.sv
module pair_detect_chk
    import pair_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [FAM_W-1:0] in_fam,
    input logic             pair_o,
    input logic [FAM_W-1:0] prev_fam_o
);
    AST_IDLE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !pair_o);  // R2

    AST_PREV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(prev_fam_o));  // R3

    AST_PREV_LOADS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> prev_fam_o == $past(in_fam));  // R3

    AST_SHIFT_MOVE_PAIRS: assert property (@(posedge clk) disable iff (rst)
        (in_vld && is_shift(prev_fam_o) && in_fam == F_MOVE) |=> pair_o);  // R4

    AST_DIV_MUL_APART: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (prev_fam_o == F_DIVU || prev_fam_o == F_DIVS)
                && (in_fam == F_MULU || in_fam == F_MULS)) |=> !pair_o);  // R8

    AST_MOVE_DBCC_APART: assert property (@(posedge clk) disable iff (rst)
        (in_vld && prev_fam_o == F_MOVE && in_fam == F_DBCC) |=> !pair_o);  // R10

    AST_UNLISTED_APART: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_fam >= 7'd40) |=> !pair_o);  // R10
endmodule

bind pair_detect pair_detect_chk u_chk (.*);

// File: tb/sim_pair_detect.sv
module sim_pair_detect;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [6:0] in_fam = 7'd0;
    logic       pair_o;
    logic [6:0] prev_fam_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    int    m_prev = 0;
    bit    m_pair = 1'b0;
    string m_tag  = "R1";

    always #2 clk = ~clk;

    pair_detect u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_fam(in_fam),
        .pair_o(pair_o), .prev_fam_o(prev_fam_o)
    );

    function automatic bit shf(int f);
        return f >= 32 && f <= 39;
    endfunction

    function automatic bit ref_pair(int a, int b);
        if (shf(a)) return b inside {[1:17]};                       // R4 R5
        if (a == 18) return b inside {1, 2, 5};                     // R6
        if (a inside {19, 20, 21}) return b == 22;                  // R7
        if (a inside {23, 24}) return b inside {1, 2, 25, 26, 27};  // R8
        if (a inside {6, 7}) return b == 1;                         // R9
        if (a inside {16, 17}) return b == 5;                       // R9
        return 1'b0;                                                // R10
    endfunction

    function automatic string ref_tag(int a, int b);
        if (a == 0) return "R1";
        if (shf(a)) return (b inside {[6:17]}) ? "R5" : "R4";
        if (a == 18) return "R6";
        if (a inside {19, 20, 21}) return "R7";
        if (a inside {[23:26]}) return "R8";
        if (a inside {6, 7, 16, 17}) return "R9";
        return "R10";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 0; m_pair = 1'b0; m_tag = "R1";
        end else if (in_vld) begin
            m_pair = ref_pair(m_prev, int'(in_fam));
            m_tag  = ref_tag(m_prev, int'(in_fam));
            m_prev = int'(in_fam);
        end else begin
            m_pair = 1'b0; m_tag = "R2";
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (pair_o !== m_pair) begin
                fails++;
                $display("FAIL %s pair_o actual=%0b expected=%0b", m_tag, pair_o, m_pair);
            end
            checks++;
            if (int'(prev_fam_o) !== m_prev) begin
                fails++;
                $display("FAIL %s prev_fam_o actual=%0d expected=%0d",
                         (m_tag == "R1") ? "R1" : "R3", prev_fam_o, m_prev);
            end
        end
    end

    task automatic put(bit v, int f);
        @(negedge clk);
        #1;
        in_vld = v;
        in_fam = 7'(f);
    endtask

    initial begin
        repeat (3) put(0, 0);
        @(negedge clk); #1 rst = 1'b0;
        // R1: first strobe after reset never pairs, even for a move
        put(1, 1);
        put(1, 34);
        put(1, 1);            // R4 shift -> move
        put(0, 0);            // R2 idle gap
        put(0, 55);           // R3 ignored family
        put(1, 23); put(1, 25); put(1, 23);  // R8 mul->div pairs, div->mul not
        put(1, 6); put(1, 2);                // R9 add -> move-to-address: no pair
        put(1, 1); put(1, 5);                // R10 move -> dbcc: no pair
        // every ordered pair of codes 0..47, back to back
        for (int a = 0; a < 48; a++) begin
            for (int b = 0; b < 48; b++) begin
                put(1, a);
                put(1, b);
            end
        end
        // random stream with gaps and unlisted codes
        for (int i = 0; i < 3000; i++) begin
            int f;
            f = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 127))
                                            : int'($urandom_range(0, 47));
            put($urandom_range(0, 9) < 7, f);
        end
        // mid-run reset right before shift -> move (R1)
        put(1, 36);
        @(negedge clk); #1 rst = 1'b1; in_vld = 1'b0;
        @(negedge clk); #1 rst = 1'b0;
        put(1, 1);
        put(1, 33);
        put(1, 12);           // R5
        put(0, 0);
        put(0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule